// File: doc/BRIEF.md
# Masked Interrupt Status Flag Register

This block holds the pending-request flags for six on-chip interrupt sources in one 8-bit status register. The sources are a timer/counter overflow, external interrupt line 1, a time-base tick, UART transmit buffer empty, UART receive buffer full and UART receive error. Each source delivers a single-cycle pulse that makes its flag sticky. Only hardware can set a flag. Software can only clear flags, by writing 0 to the bits it wants cleared. The receive-error flag is also forced clear for as long as the UART is disabled.

A companion mask register sits beside the status register. Reading the status address returns the flags ANDed with the mask, never the raw flags. The combined interrupt request output is high whenever any flag that is both pending and unmasked is set. Both registers are reached through a simple single-cycle write port with address decode. Reads are combinational from the current address.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset, every flag and every mask bit is 0, both register addresses read 0x00, and `irq` is low.
- R2: A one-cycle pulse on a source input sets that source's flag at the next clock edge. The flag positions are: overflow bit 0, external line 1 bit 2, tick bit 3, transmit empty bit 4, receive full bit 5, receive error bit 6.
- R3: A write to the status address (0x0F) clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A write never sets a flag.
- R4: When a set pulse and a software clear reach the same flag in the same cycle, the flag ends up set.
- R5: A read of the status address returns (flags AND mask) on every bit, with bits 7 and 1 always 0.
- R6: The mask register at address 0x0E can be written and read back. Its bits 7 and 1 always read 0.
- R7: While `uart_off` is high, the receive-error flag (bit 6) is cleared at each clock edge, and this clear takes priority over a simultaneous receive-error pulse.
- R8: `irq` is high exactly when (flags AND mask) is non-zero.
- R9: Any address other than 0x0F and 0x0E reads 0x00, and a write to such an address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| uart_off | input | 1 | UART disabled; holds the receive-error flag clear |
| ev_tmr_ovf | input | 1 | Timer/counter overflow pulse |
| ev_ext1 | input | 1 | External interrupt line 1 pulse |
| ev_tick | input | 1 | Time-base tick pulse |
| ev_tx_empty | input | 1 | UART transmit buffer empty pulse |
| ev_rx_full | input | 1 | UART receive buffer full pulse |
| ev_rx_err | input | 1 | UART receive error pulse |
| irq | output | 1 | Combined masked interrupt request |

## Verification
Several rules are checked by assertions on every cycle. A pulse always leaves its flag set, so set beats clear. A write never raises a flag. The disabled UART keeps bit 6 low. The status readback and `irq` always match the masked flags. The unused bits stay zero. Only the bench scenarios can show the full mapping. In each of them the bench pulses a pattern of sources, then sweeps the mask through all 256 values and reads the status back each time. Those same scenarios also cover partial clears with mixed data bits, the exact cycle at which a flag appears, and writes to unrelated addresses leaving both registers untouched.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_SRC = 6;

  // flag positions inside the status word
  localparam int POS_OVF   = 0;
  localparam int POS_EXT1  = 2;
  localparam int POS_TICK  = 3;
  localparam int POS_TXE   = 4;
  localparam int POS_RXF   = 5;
  localparam int POS_RXERR = 6;

  localparam logic [REG_W-1:0] USED_BITS = 8'h7D;

  // place source pulses (index 0..5: ovf, ext1, tick, txe, rxf, rxerr) on flag bits
  function automatic logic [REG_W-1:0] place_sources(input logic [NUM_SRC-1:0] ev);
    logic [REG_W-1:0] v;
    v = '0;
    v[POS_OVF]   = ev[0];
    v[POS_EXT1]  = ev[1];
    v[POS_TICK]  = ev[2];
    v[POS_TXE]   = ev[3];
    v[POS_RXF]   = ev[4];
    v[POS_RXERR] = ev[5];
    return v;
  endfunction
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic sw_clr_i,
  input  logic hw_clr_i,
  output logic q
);
  // priority: hardware clear, then set, then software clear
  always_ff @(posedge clk) begin
    if (rst)           q <= 1'b0;
    else if (hw_clr_i) q <= 1'b0;
    else if (set_i)    q <= 1'b1;
    else if (sw_clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d & KEEP;
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
  parameter int ADDR_W = 8,
  parameter int W      = 8
) (
  input  logic         sel_stat,
  input  logic         sel_mask,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] mask,
  output logic [W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (sel_stat)      rdata = flags & mask;
    else if (sel_mask) rdata = mask;
  end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irq_flag_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0F,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h0E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              uart_off,
  input  logic              ev_tmr_ovf,
  input  logic              ev_ext1,
  input  logic              ev_tick,
  input  logic              ev_tx_empty,
  input  logic              ev_rx_full,
  input  logic              ev_rx_err,
  output logic              irq
);
  logic              sel_stat, sel_mask;
  logic [REG_W-1:0]  set_pos;
  logic [REG_W-1:0]  flags_q;
  logic [REG_W-1:0]  mask_q;

  assign sel_stat = (bus_addr == STAT_ADDR);
  assign sel_mask = (bus_addr == MASK_ADDR);
  assign set_pos  = place_sources({ev_rx_err, ev_rx_full, ev_tx_empty,
                                   ev_tick, ev_ext1, ev_tmr_ovf});

  for (genvar i = 0; i < REG_W; i++) begin : g_flag
    if (USED_BITS[i]) begin : g_used
      logic hw_clr;
      if (i == POS_RXERR) begin : g_uart
        assign hw_clr = uart_off;
      end else begin : g_plain
        assign hw_clr = 1'b0;
      end
      irq_flag_cell u_cell (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_pos[i]),
        .sw_clr_i (bus_wr & sel_stat & ~bus_wdata[i]),
        .hw_clr_i (hw_clr),
        .q        (flags_q[i])
      );
    end else begin : g_unused
      assign flags_q[i] = 1'b0;
    end
  end

  irq_mask_reg #(.W(REG_W), .KEEP(USED_BITS)) u_mask (
    .clk (clk),
    .rst (rst),
    .we  (bus_wr & sel_mask),
    .d   (bus_wdata),
    .q   (mask_q)
  );

  irq_read_mux #(.ADDR_W(ADDR_W), .W(REG_W)) u_rd (
    .sel_stat (sel_stat),
    .sel_mask (sel_mask),
    .flags    (flags_q),
    .mask     (mask_q),
    .rdata    (bus_rdata)
  );

  assign irq = |(flags_q & mask_q);
endmodule

// File: rtl/irq_flag_reg_chk.sv
module irq_flag_reg_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0F
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        rdata,
  input logic              irq,
  input logic              uart_off,
  input logic [7:0]        flags,
  input logic [7:0]        mask,
  input logic [7:0]        set_pos
);
  logic [7:0] keep_set;
  assign keep_set = set_pos & ~(uart_off ? 8'h40 : 8'h00);

  // R2 R4
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (keep_set != 8'h00) |=> ((flags & $past(keep_set)) == $past(keep_set)));

  // R3
  no_sw_set_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(set_pos)) == 8'h00));

  // R7
  uart_off_clear_chk: assert property (@(posedge clk) disable iff (rst)
    uart_off |=> !flags[6]);

  // R5
  stat_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == STAT_ADDR) |-> (rdata == (flags & mask)));

  // R8
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == ((flags & mask) != 8'h00));

  // R6
  unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (flags[7] | flags[1] | mask[7] | mask[1]) == 1'b0);
endmodule

bind irq_flag_reg irq_flag_reg_chk #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .rdata    (bus_rdata),
  .irq      (irq),
  .uart_off (uart_off),
  .flags    (flags_q),
  .mask     (mask_q),
  .set_pos  (set_pos)
);

// File: tb/irq_flag_reg_tb.sv
`timescale 1ns/1ps
module irq_flag_reg_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       uart_off = 1'b0;
  logic [5:0] ev = 6'd0;
  logic       irq;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  localparam logic [7:0] A_STAT = 8'h0F;
  localparam logic [7:0] A_MASK = 8'h0E;

  always #5 clk = ~clk;

  irq_flag_reg u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .uart_off(uart_off),
    .ev_tmr_ovf(ev[0]), .ev_ext1(ev[1]), .ev_tick(ev[2]),
    .ev_tx_empty(ev[3]), .ev_rx_full(ev[4]), .ev_rx_err(ev[5]), .irq(irq)
  );

  // source k lands on bit 0 for k=0, else on bit k+1
  function automatic logic [7:0] expand(input logic [5:0] p);
    logic [7:0] v = 8'h00;
    for (int k = 0; k < 6; k++)
      if (p[k]) v = v | (8'h01 << ((k == 0) ? 0 : k + 1));
    return v;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] p);
    @(negedge clk);
    ev = p;
    @(negedge clk);
    ev = 6'd0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(bus_rdata, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(A_STAT, 8'h00, "R1 status");
    rd(A_MASK, 8'h00, "R1 mask");
    check({7'd0, irq}, 8'h00, "R1 irq");

    // R6 mask write/readback
    wr(A_MASK, 8'hFF);
    rd(A_MASK, 8'h7D, "R6 mask all ones");
    wr(A_MASK, 8'h2A);
    rd(A_MASK, 8'h28, "R6 mask pattern");

    // R2 R5 R8 sweep: every source pattern against every mask value
    for (int p = 0; p < 64; p++) begin
      wr(A_STAT, 8'h00);
      pulse(p[5:0]);
      for (int m = 0; m < 256; m++) begin
        wr(A_MASK, m[7:0]);
        rd(A_STAT, expand(p[5:0]) & m[7:0] & 8'h7D, "R2 R5 masked read");
        check({7'd0, irq}, {7'd0, ((expand(p[5:0]) & m[7:0] & 8'h7D) != 0)}, "R8 irq");
      end
    end

    // R3 partial clear, and writes of 1 never set
    wr(A_MASK, 8'hFF);
    wr(A_STAT, 8'h00);
    wr(A_STAT, 8'hFF);
    rd(A_STAT, 8'h00, "R3 write ones does not set");
    pulse(6'h3F);
    wr(A_STAT, 8'hAA);
    rd(A_STAT, 8'h28, "R3 partial clear");

    // R4 set beats clear in the same cycle (tick bit 3)
    wr(A_STAT, 8'h00);
    @(negedge clk);
    bus_addr = A_STAT; bus_wdata = 8'h00; bus_wr = 1'b1; ev = 6'h04;
    @(negedge clk);
    bus_wr = 1'b0; ev = 6'd0;
    rd(A_STAT, 8'h08, "R4 set wins");

    // R2 flag appears one edge after pulse
    wr(A_STAT, 8'h00);
    @(negedge clk);
    ev = 6'h01; bus_addr = A_STAT;
    #1 check(bus_rdata, 8'h00, "R2 not before edge");
    @(negedge clk);
    ev = 6'd0;
    rd(A_STAT, 8'h01, "R2 after edge");

    // R7 uart disable clears receive error and beats its pulse
    wr(A_STAT, 8'h00);
    pulse(6'h20);
    rd(A_STAT, 8'h40, "R7 err set");
    @(negedge clk); uart_off = 1'b1;
    @(negedge clk);
    rd(A_STAT, 8'h00, "R7 cleared by disable");
    pulse(6'h30);
    rd(A_STAT, 8'h20, "R7 pulse ignored while off");
    @(negedge clk); uart_off = 1'b0;

    // R9 other addresses
    pulse(6'h3F);
    wr(8'h05, 8'h00);
    rd(A_STAT, 8'h7D, "R9 flags untouched");
    rd(A_MASK, 8'h7D, "R9 mask untouched");
    rd(8'h05, 8'h00, "R9 other addr reads 0");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule